// File: doc/BRIEF.md
# I/O Space Request Gate

This block is the front end of a non-cacheable I/O unit. It takes one read or write request at a time. Each request carries a 40-bit physical address, 64 bits of write data and an 8-bit byte-enable. The block sorts the request by the top address byte (bits 39:32) into one of four classes: open, reserved, boot (read-only), or forbidden. It then answers one cycle later with a 128-bit read word, an error flag, a pulse that marks a rule violation, and a separate pulse for addresses that should never reach this unit.

A sixteen-entry, byte-writable store stands in for the registers behind the open regions. One fixed address returns pseudo-random data from a 64-bit shift register instead of stored data. A bypass input relaxes the rules for environments that want every access to go through. The violation pulse still reports what would have been disallowed under the normal rules.

Top module: `io_access_gate`

## Requirements
- R1: After reset, rsp_valid, rsp_err, fail_pulse and proto_viol are 0, req_ready is 1, and every store entry reads as zero.
- R2: Address bits 2:0 are ignored. The request is decoded as if they were zero.
- R3: Open regions are top bytes 0x80, 0x81, 0x83–0x86, 0x88, 0x89, 0x90 and 0xC0–0xCF. Reads there return the stored 64-bit word copied into both halves of rsp_data. Writes there update only the bytes whose enable bit is 1 (bit i covers data bits 8i+7:8i). rsp_err stays 0 in both cases.
- R4: Reserved regions are top byte values below 0x80, 0x82, 0x87, 0x8A–0x8F, 0x91–0x9F and 0xD0–0xFE. A read there, without bypass, returns rsp_err = 1, the filler pattern {8{16'hDEAD}} and a fail_pulse.
- R5: A write to a reserved region, without bypass, has rsp_err = 0, changes no store entry, and raises fail_pulse.
- R6: Top byte 0xFF is read-only. A read there returns store data with no error. A write there never changes the store, raises fail_pulse, and raises rsp_err unless bypass is 1.
- R7: Top bytes 0xA0–0xBF raise proto_viol with the response. Without bypass, a read there returns the filler pattern, a write there is dropped, and rsp_err stays 0.
- R8: A read of aligned address 0x83_0000_0030 returns the current 64-bit random value S in both halves of rsp_data. S then advances to {S[62:0], S[63]^S[62]^S[60]^S[59]}, starting from RNG_SEED. A write to that address is an ordinary open-region write.
- R9: With bypass = 1, rsp_err is always 0. Reads return store data in every region except top byte 0x82, which returns the filler. Writes update the store in every region except 0xFF. fail_pulse is still raised for reserved accesses and 0xFF writes.
- R10: The response (rsp_valid and its data and flags) appears for exactly one cycle, in the cycle after the request is accepted. req_ready is 0 while a response is pending.
- R11: The store entry is selected by addr[35:32] ^ addr[39:36] ^ {1'b0, addr[5:3]}, so different addresses can share an entry. A write response carries the filler pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical address |
| req_wdata | input | 64 | Write data |
| req_mask | input | 8 | Byte enables for writes |
| bypass | input | 1 | Relaxed-check mode |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 128 | Read data, 64-bit value copied into both halves |
| rsp_err | output | 1 | Access error flag |
| fail_pulse | output | 1 | Access would be disallowed under normal rules |
| proto_viol | output | 1 | Address in the never-expected range |

## Verification
The bench sweeps all 256 top-byte values with reads and writes, both with and without bypass. It checks each response against a model of the store and of the classes.

A design that confused a dropped write with a rejected write would either show rsp_err on reserved writes or let the write land in the store. A later read of the aliased entry would then expose it.

The bench also targets several other mistakes:
- A decoder that ignored the 0x82 exception in bypass would return stored data where the filler is expected.
- One that let 0xFF writes through in bypass would corrupt the entry.
- Reads of the random address, including one with nonzero low address bits, must follow the shift sequence exactly. A generator that advanced on every cycle, or not at all, produces the wrong values.

// File: rtl/io_access_gate.sv
module io_access_gate #(
  parameter int          IDX_W    = 4,
  parameter logic [63:0] RNG_SEED = 64'h9E37_79B9_7F4A_7C15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [39:0]  req_addr,
  input  logic [63:0]  req_wdata,
  input  logic [7:0]   req_mask,
  input  logic         bypass,
  output logic         req_ready,
  output logic         rsp_valid,
  output logic [127:0] rsp_data,
  output logic         rsp_err,
  output logic         fail_pulse,
  output logic         proto_viol
);
  localparam int           DEPTH  = 1 << IDX_W;
  localparam logic [127:0] FILLER = {8{16'hDEAD}};
  localparam logic [39:0]  RNG_AD = 40'h83_0000_0030;

  logic [63:0]      mem [DEPTH];
  logic [63:0]      lfsr;
  logic [39:0]      a;
  logic [7:0]       rg;
  logic [IDX_W-1:0] idx;
  logic             accept, open_rg, boot, forbid, resv, rng_hit;
  logic             do_write, rd_store, nxt_err, nxt_fail;
  logic [127:0]     nxt_data;

  assign a         = req_addr & ~40'h7;
  assign rg        = a[39:32];
  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign idx       = IDX_W'(a[35:32] ^ a[39:36] ^ {1'b0, a[5:3]});

  always_comb begin
    case (rg)
      8'h80, 8'h81, 8'h83, 8'h84, 8'h85, 8'h86, 8'h88, 8'h89, 8'h90: open_rg = 1'b1;
      default: open_rg = (rg[7:4] == 4'hC);
    endcase
  end

  assign boot    = (rg == 8'hFF);
  assign forbid  = (rg[7:5] == 3'b101);
  assign resv    = !(open_rg || boot || forbid);
  assign rng_hit = !req_write && (a == RNG_AD);

  assign do_write = req_write && (open_rg || (bypass && !boot));
  assign rd_store = !req_write && (open_rg || boot || (bypass && rg != 8'h82));
  assign nxt_err  = !bypass && (req_write ? boot : resv);
  assign nxt_fail = resv || (req_write && boot);
  assign nxt_data = req_write ? FILLER :
                    rng_hit   ? {lfsr, lfsr} :
                    rd_store  ? {mem[idx], mem[idx]} : FILLER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (accept && do_write) begin
      for (int b = 0; b < 8; b++)
        if (req_mask[b]) mem[idx][8*b +: 8] <= req_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= RNG_SEED;
    else if (accept && rng_hit) lfsr <= {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      fail_pulse <= 1'b0;
      proto_viol <= 1'b0;
      rsp_data   <= FILLER;
    end else begin
      rsp_valid  <= accept;
      rsp_err    <= accept && nxt_err;
      fail_pulse <= accept && nxt_fail;
      proto_viol <= accept && forbid;
      if (accept) rsp_data <= nxt_data;
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_BYPASS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bypass) |=> !rsp_err); // R9
  AST_FLAGS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err || fail_pulse || proto_viol) |-> rsp_valid); // R4
  AST_FORBID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[39:37] == 3'b101) |=> proto_viol && !rsp_err); // R7
  AST_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !bypass && req_addr[39:32] == 8'hFF)
      |=> rsp_err && fail_pulse); // R6
  AST_RESV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !bypass && req_addr[39:32] == 8'h87)
      |=> rsp_err && rsp_data == FILLER); // R4
endmodule

// File: tb/sim_io_access_gate.sv
module sim_io_access_gate;
  localparam logic [63:0]  SEED   = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [127:0] FILLER = {8{16'hDEAD}};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, bypass = 0;
  logic [39:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_mask = '0;
  logic req_ready, rsp_valid, rsp_err, fail_pulse, proto_viol;
  logic [127:0] rsp_data;

  int tests = 0, fails = 0;
  logic [63:0] mdl [16];
  logic [63:0] lf;

  always #5 clk = ~clk;

  io_access_gate #(.RNG_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .bypass(bypass),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .fail_pulse(fail_pulse), .proto_viol(proto_viol));

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic req(input logic w, input logic [39:0] ad, input logic [63:0] d,
                     input logic [7:0] m, input logic byp, input string force_tag);
    logic [39:0] aa;
    logic [7:0] rg;
    logic [3:0] ix;
    logic op, bt, fb, rs, rng;
    logic e_err, e_fail, e_proto;
    logic [127:0] e_data;
    string tag;
    aa  = {ad[39:3], 3'b000};
    rg  = aa[39:32];
    ix  = aa[35:32] ^ aa[39:36] ^ {1'b0, aa[5:3]};
    op  = rg inside {8'h80, 8'h81, 8'h83, 8'h84, 8'h85, 8'h86, 8'h88, 8'h89, 8'h90, [8'hC0:8'hCF]};
    bt  = (rg == 8'hFF);
    fb  = (rg >= 8'hA0 && rg <= 8'hBF);
    rs  = !op && !bt && !fb;
    rng = !w && aa == 40'h83_0000_0030;
    e_proto = fb;
    e_fail  = rs || (w && bt);
    e_err   = byp ? 1'b0 : (w ? bt : rs);
    e_data  = FILLER;
    if (rng) begin
      e_data = {lf, lf};
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
    end else if (!w && (op || bt || (byp && rg != 8'h82))) e_data = {mdl[ix], mdl[ix]};
    if (w && (op || (byp && !bt)))
      for (int b = 0; b < 8; b++) if (m[b]) mdl[ix][8*b +: 8] = d[8*b +: 8];
    if (force_tag != "") tag = force_tag;
    else if (rng) tag = "R8";
    else if (byp) tag = "R9";
    else if (fb) tag = "R7";
    else if (bt) tag = "R6";
    else if (rs) tag = w ? "R5" : "R4";
    else tag = "R3";
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = ad; req_wdata = d; req_mask = m; bypass = byp;
    @(negedge clk);
    req_valid = 0;
    chk("R10", "rsp_valid", {127'b0, rsp_valid}, 128'd1);
    chk("R10", "req_ready busy", {127'b0, req_ready}, 128'd0);
    chk(tag, "rsp_err", {127'b0, rsp_err}, {127'b0, e_err});
    chk(tag, "fail_pulse", {127'b0, fail_pulse}, {127'b0, e_fail});
    chk(tag, "proto_viol", {127'b0, proto_viol}, {127'b0, e_proto});
    chk(tag, "rsp_data", rsp_data, e_data);
    @(negedge clk);
    chk("R10", "rsp_valid one cycle", {127'b0, rsp_valid}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    lf = SEED;
    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_valid", {127'b0, rsp_valid}, 128'd0);
    chk("R1", "reset req_ready", {127'b0, req_ready}, 128'd1);
    chk("R1", "reset flags", {125'b0, rsp_err, fail_pulse, proto_viol}, 128'd0);
    rst_n = 1;
    req(0, 40'h80_0000_0000, 0, 0, 0, "R1");
    req(1, 40'h84_0000_0107, 64'h1122_3344_5566_7788, 8'hFF, 0, "R2");
    req(0, 40'h84_0000_0100, 0, 0, 0, "R2");
    req(1, 40'h84_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 0, "R3");
    req(0, 40'h84_0000_0100, 0, 0, 0, "R3");
    req(1, 40'h80_0000_0000, 64'hA5A5_0000_5A5A_1111, 8'hFF, 0, "R11");
    req(0, 40'h81_0000_0008, 0, 0, 0, "R11");
    for (int k = 0; k < 3; k++) req(0, 40'h83_0000_0030, 0, 0, 0, "R8");
    req(0, 40'h83_0000_0035, 0, 0, 0, "R8");
    req(1, 40'h83_0000_0030, 64'h0123_4567_89AB_CDEF, 8'hFF, 0, "R8");
    req(0, 40'h83_0000_0030, 0, 0, 0, "R8");
    for (int r = 0; r < 256; r++) begin
      logic [39:0] ad;
      ad = {r[7:0], 32'h0000_1000} | 40'({r[5:0], 3'b101});
      req(0, ad, 0, 0, 0, "");
      req(1, ad, {8{r[7:0]}} ^ 64'h0F1E_2D3C_4B5A_6978, r[7:0] | 8'h81, 0, "");
      req(0, ad, 0, 0, 0, "");
    end
    for (int r = 0; r < 256; r++) begin
      logic [39:0] ad;
      ad = {r[7:0], 32'h0000_2000} | 40'({r[4:0], 3'b011});
      req(1, ad, {4{r[7:0], 8'h3C}}, 8'hFF, 1, "");
      req(0, ad, 0, 0, 1, "");
    end
    req(0, 40'h83_0000_0030, 0, 0, 1, "R8");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule